// File: doc/BRIEF.md
# Widening Saturating Scaled Multiply-Accumulate Unit

This block is the per-element arithmetic core for a vector widening multiply-accumulate with fixed-point scaling. Each accepted element supplies two narrow operands of `SEW` bits, a `2*SEW`-bit accumulator value and a 2-bit rounding-mode control. The unit multiplies the operands at full precision and shifts the product right by `SEW/2` bits. The increment chosen by the rounding mode is added back in. The result is then merged into the accumulator with clamping arithmetic. A per-element flag marks each clamped result, and a sticky flag records that clamping has occurred since reset.

The caller passes the three instruction fields that select the operation. From them the unit decodes which of four signedness variants applies and whether the second multiplicand comes from the vector element or from the scalar operand. The vector element, or the scalar operand already cut to `SEW` bits, is the second multiplicand. The other vector element is always the first. Elements enter with a valid/ready handshake, pass through a multiply stage and a round-and-clamp stage, and leave in order with a valid/ready handshake. A full pipeline stalls under back-pressure.

Top module: `wsmac_unit`

## Requirements
- R1: An element is legal only when the opcode field (`in_opcode`) equals 1010111 and the sub-function field (`in_funct3`) is 000 (vector) or 100 (scalar). The variant field (`in_funct6`) must also be one of 111100, 111101, 111110, or 111111 with the scalar form only. Any other combination gives `out_illegal`=1 with `out_result` equal to the input accumulator and `out_sat`=0. A legal element gives `out_illegal`=0.
- R2: With sub-function 100, the second multiplicand is `in_scalar` and `in_vs1` has no effect. With sub-function 000, it is `in_vs1` and `in_scalar` has no effect. `in_vs2` is always the first multiplicand.
- R3: The product is shifted right by SEW/2 bits, arithmetically for signed products. With `in_rnd`=00, the most significant shifted-out bit is added to the shifted value.
- R4: With `in_rnd`=01, rounding is to nearest with ties to even. One is added when the discarded part exceeds half an LSB, or equals half an LSB while the kept value is odd.
- R5: With `in_rnd`=10, the discarded bits are dropped, which rounds toward minus infinity.
- R6: With `in_rnd`=11, the LSB of the kept value is forced to 1 whenever any discarded bit is nonzero.
- R7: Variant 111100 treats both multiplicands and the accumulator as unsigned and adds. A sum above 2^(2*SEW)-1 yields all ones with `out_sat`=1.
- R8: Variant 111101 treats both multiplicands and the accumulator as signed two's complement and adds. The result is clamped to [-2^(2*SEW-1), 2^(2*SEW-1)-1], and `out_sat`=1 when clamping occurs.
- R9: Variant 111110 (first multiplicand unsigned, second signed) and variant 111111 (first signed, second unsigned) subtract the scaled product from the signed accumulator. They clamp as in R8.
- R10: `sat_sticky` is 0 until an element with `out_sat`=1 is presented, and stays 1 from then until reset.
- R11: With `out_ready` held high, an element accepted on one rising edge is presented on `out_valid`/`out_result` after the second following edge. Elements leave in acceptance order, one per cycle.
- R12: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and the presented result, flags and valid stay unchanged.
- R13: After reset, `out_valid`=0, `sat_sticky`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element present |
| in_ready | output | 1 | Unit accepts an element this cycle |
| in_funct6 | input | 6 | Variant field of the instruction |
| in_funct3 | input | 3 | Operand-source field of the instruction |
| in_opcode | input | 7 | Major opcode field of the instruction |
| in_rnd | input | 2 | Rounding mode: 00 nearest-up, 01 nearest-even, 10 truncate, 11 odd |
| in_vs2 | input | SEW | First multiplicand (vector element) |
| in_vs1 | input | SEW | Second multiplicand, vector form |
| in_scalar | input | SEW | Second multiplicand, scalar form (low SEW bits of the scalar register) |
| in_acc | input | 2*SEW | Accumulator element |
| out_ready | input | 1 | Downstream accepts the result |
| out_valid | output | 1 | Result present |
| out_result | output | 2*SEW | Clamped accumulated result |
| out_sat | output | 1 | This result was clamped |
| out_illegal | output | 1 | This element had an unrecognised encoding |
| sat_sticky | output | 1 | Clamping has occurred since reset |

## Verification
The bench builds the unit with SEW=8, so the product is 16 bits, the shift is 4 bits and the accumulator is 16 bits. At that width every first multiplicand paired with a dense spread of second multiplicands is affordable for every variant and both operand sources. All four rounding modes are swept on the signed variant, and an accumulator set near both clamping limits drives saturation in every direction. Streaming at one element per cycle exposes ordering and latency. Directed stall and illegal-encoding sequences cover the handshake and decode paths.

// File: rtl/wsmac_pkg.sv
package wsmac_pkg;

    // Signedness / combine variant, indexed by the low two variant bits
    typedef enum logic [1:0] {
        WS_UU_ADD  = 2'd0,   // both unsigned, saturating add
        WS_SS_ADD  = 2'd1,   // both signed, saturating add
        WS_UXS_SUB = 2'd2,   // first unsigned, second signed, saturating subtract
        WS_SXU_SUB = 2'd3    // first signed, second unsigned, saturating subtract
    } ws_kind_e;

    typedef enum logic [1:0] {
        RND_NEAR_UP   = 2'd0,
        RND_NEAR_EVEN = 2'd1,
        RND_TRUNC     = 2'd2,
        RND_ODD       = 2'd3
    } ws_rnd_e;

    typedef struct packed {
        logic     legal;
        logic     use_scalar;
        ws_kind_e kind;
    } ws_dec_t;

    localparam logic [6:0] WS_OPCODE   = 7'b1010111;
    localparam logic [2:0] WS_F3_VEC   = 3'b000;
    localparam logic [2:0] WS_F3_SCAL  = 3'b100;
    localparam logic [3:0] WS_F6_GROUP = 4'b1111;

endpackage

// File: rtl/wsmac_decode.sv
module wsmac_decode
    import wsmac_pkg::*;
(
    input  logic [5:0] funct6,
    input  logic [2:0] funct3,
    input  logic [6:0] opcode,
    output ws_dec_t    dec
);
    logic form_ok;
    logic group_ok;

    always_comb begin
        group_ok       = (opcode == WS_OPCODE) && (funct6[5:2] == WS_F6_GROUP);
        // the signed-by-unsigned ordering has no vector form
        form_ok        = (funct3 == WS_F3_SCAL) ||
                         ((funct3 == WS_F3_VEC) && (funct6[1:0] != 2'b11));
        dec.legal      = group_ok && form_ok;
        dec.use_scalar = (funct3 == WS_F3_SCAL);
        dec.kind       = ws_kind_e'(funct6[1:0]);
    end
endmodule

// File: rtl/wsmac_mul.sv
module wsmac_mul #(
    parameter int SEW = 32
) (
    input  logic [SEW-1:0]          op_a,
    input  logic [SEW-1:0]          op_b,
    input  logic                    a_signed,
    input  logic                    b_signed,
    output logic signed [2*SEW+1:0] prod
);
    localparam int PW = 2 * SEW + 2;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;

    always_comb begin
        a_ext = {{(PW-SEW){a_signed & op_a[SEW-1]}}, op_a};
        b_ext = {{(PW-SEW){b_signed & op_b[SEW-1]}}, op_b};
        prod  = a_ext * b_ext;
    end
endmodule

// File: rtl/wsmac_rndsat.sv
module wsmac_rndsat
    import wsmac_pkg::*;
#(
    parameter int SEW = 32
) (
    input  logic signed [2*SEW+1:0] prod,
    input  logic [2*SEW-1:0]        acc,
    input  ws_kind_e                kind,
    input  ws_rnd_e                 rnd,
    input  logic                    legal,
    output logic [2*SEW-1:0]        result,
    output logic                    sat
);
    localparam int AW = 2 * SEW;
    localparam int PW = AW + 2;
    localparam int H  = SEW / 2;
    localparam int SW = PW - H;
    localparam int CW = AW + 2;

    logic [SW-1:0] kept;
    logic          guard;
    logic          sticky;
    logic          lsb;
    logic          incr;
    logic [CW-1:0] scaled;
    logic [CW-1:0] acc_x;
    logic [CW-1:0] sum;
    logic          is_sub;

    always_comb begin
        kept   = prod[PW-1:H];
        guard  = prod[H-1];
        sticky = |prod[H-2:0];
        lsb    = prod[H];
        incr   = 1'b0;
        case (rnd)
            RND_NEAR_UP:   incr = guard;
            RND_NEAR_EVEN: incr = guard & (sticky | lsb);
            RND_TRUNC:     incr = 1'b0;
            RND_ODD:       incr = ~lsb & (guard | sticky);
            default:       incr = 1'b0;
        endcase
        scaled = {{(CW-SW){kept[SW-1]}}, kept} + CW'(incr);
        acc_x  = (kind == WS_UU_ADD) ? {2'b00, acc} : {{2{acc[AW-1]}}, acc};
        is_sub = (kind == WS_UXS_SUB) || (kind == WS_SXU_SUB);
        sum    = is_sub ? (acc_x - scaled) : (acc_x + scaled);

        result = sum[AW-1:0];
        sat    = 1'b0;
        if (!legal) begin
            result = acc;
        end else if (kind == WS_UU_ADD) begin
            if (sum[AW]) begin
                result = '1;
                sat    = 1'b1;
            end
        end else if (sum[CW-1:AW-1] != {3{sum[CW-1]}}) begin
            sat    = 1'b1;
            result = sum[CW-1] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
        end
    end
endmodule

// File: rtl/wsmac_unit.sv
module wsmac_unit
    import wsmac_pkg::*;
#(
    parameter int SEW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [5:0]         in_funct6,
    input  logic [2:0]         in_funct3,
    input  logic [6:0]         in_opcode,
    input  logic [1:0]         in_rnd,
    input  logic [SEW-1:0]     in_vs2,
    input  logic [SEW-1:0]     in_vs1,
    input  logic [SEW-1:0]     in_scalar,
    input  logic [2*SEW-1:0]   in_acc,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [2*SEW-1:0]   out_result,
    output logic               out_sat,
    output logic               out_illegal,
    output logic               sat_sticky
);
    localparam int AW = 2 * SEW;
    localparam int PW = AW + 2;

    typedef struct packed {
        logic                 s1_vld;
        logic                 s1_legal;
        ws_kind_e             s1_kind;
        ws_rnd_e              s1_rnd;
        logic signed [PW-1:0] s1_prod;
        logic [AW-1:0]        s1_acc;
        logic                 s2_vld;
        logic [AW-1:0]        s2_res;
        logic                 s2_sat;
        logic                 s2_ill;
        logic                 sticky;
    } pipe_t;

    pipe_t st_d, st_q;

    ws_dec_t              dec;
    logic [SEW-1:0]       mul_b;
    logic                 a_sgn;
    logic                 b_sgn;
    logic signed [PW-1:0] prod_w;
    logic [AW-1:0]        res_w;
    logic                 sat_w;
    logic                 advance;

    wsmac_decode u_dec (
        .funct6 (in_funct6),
        .funct3 (in_funct3),
        .opcode (in_opcode),
        .dec    (dec)
    );

    always_comb begin
        mul_b = dec.use_scalar ? in_scalar : in_vs1;
        a_sgn = (dec.kind == WS_SS_ADD) || (dec.kind == WS_SXU_SUB);
        b_sgn = (dec.kind == WS_SS_ADD) || (dec.kind == WS_UXS_SUB);
    end

    wsmac_mul #(.SEW(SEW)) u_mul (
        .op_a     (in_vs2),
        .op_b     (mul_b),
        .a_signed (a_sgn),
        .b_signed (b_sgn),
        .prod     (prod_w)
    );

    wsmac_rndsat #(.SEW(SEW)) u_rs (
        .prod   (st_q.s1_prod),
        .acc    (st_q.s1_acc),
        .kind   (st_q.s1_kind),
        .rnd    (st_q.s1_rnd),
        .legal  (st_q.s1_legal),
        .result (res_w),
        .sat    (sat_w)
    );

    assign advance = !st_q.s2_vld || out_ready;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.s1_vld = in_valid;
            if (in_valid) begin
                st_d.s1_legal = dec.legal;
                st_d.s1_kind  = dec.kind;
                st_d.s1_rnd   = ws_rnd_e'(in_rnd);
                st_d.s1_prod  = prod_w;
                st_d.s1_acc   = in_acc;
            end
            st_d.s2_vld = st_q.s1_vld;
            if (st_q.s1_vld) begin
                st_d.s2_res = res_w;
                st_d.s2_sat = sat_w;
                st_d.s2_ill = !st_q.s1_legal;
                st_d.sticky = st_q.sticky | sat_w;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready    = advance;
    assign out_valid   = st_q.s2_vld;
    assign out_result  = st_q.s2_res;
    assign out_sat     = st_q.s2_sat;
    assign out_illegal = st_q.s2_ill;
    assign sat_sticky  = st_q.sticky;

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
                                       $stable(out_sat) && $stable(out_illegal)));
    // R12
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    // R10
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sat_sticky |=> sat_sticky);
    // R10
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sat) |-> sat_sticky);
    // R7 R8 R9
    clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sat) |-> ((out_result == {AW{1'b1}}) ||
                                    (out_result == {1'b1, {(AW-1){1'b0}}}) ||
                                    (out_result == {1'b0, {(AW-1){1'b1}}})));
    // R1
    illegal_nosat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> !out_sat);
endmodule

// File: tb/wsmac_unit_tb.sv
`timescale 1ns/1ps
module wsmac_unit_tb;
    localparam int SEW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [5:0]  in_funct6 = '0;
    logic [2:0]  in_funct3 = '0;
    logic [6:0]  in_opcode = '0;
    logic [1:0]  in_rnd = '0;
    logic [7:0]  in_vs2 = '0, in_vs1 = '0, in_scalar = '0;
    logic [15:0] in_acc = '0;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic [15:0] out_result;
    logic        out_sat, out_illegal, sat_sticky;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] res;
        logic        sat;
        logic        ill;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    wsmac_unit #(.SEW(SEW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_funct6(in_funct6), .in_funct3(in_funct3), .in_opcode(in_opcode),
        .in_rnd(in_rnd), .in_vs2(in_vs2), .in_vs1(in_vs1), .in_scalar(in_scalar),
        .in_acc(in_acc), .out_ready(out_ready), .out_valid(out_valid),
        .out_result(out_result), .out_sat(out_sat), .out_illegal(out_illegal),
        .sat_sticky(sat_sticky)
    );

    task automatic cmp(input string tag, input longint got, input longint want);
        n_chk++;
        if (got != want) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, want);
        end
    endtask

    function automatic exp_t model(input logic [5:0] f6, input logic [2:0] f3,
                                   input logic [6:0] op, input logic [1:0] md,
                                   input logic [7:0] v2, input logic [7:0] v1,
                                   input logic [7:0] sc, input logic [15:0] acc);
        exp_t   e;
        longint a, b, p, q, rm, s, t;
        int     r;
        bit     a_s, b_s, legal;
        logic [7:0] bs;
        legal = (op == 7'h57) && (f3 == 3'd0 || f3 == 3'd4) &&
                (f6 == 6'h3C || f6 == 6'h3D || f6 == 6'h3E || (f6 == 6'h3F && f3 == 3'd4));
        if (!legal) begin
            e.res = acc; e.sat = 1'b0; e.ill = 1'b1; e.tag = "R1";
            return e;
        end
        bs  = (f3 == 3'd4) ? sc : v1;
        a_s = (f6 == 6'h3D) || (f6 == 6'h3F);
        b_s = (f6 == 6'h3D) || (f6 == 6'h3E);
        a   = a_s ? longint'($signed(v2)) : longint'(v2);
        b   = b_s ? longint'($signed(bs)) : longint'(bs);
        p   = a * b;
        q   = p >>> 4;
        rm  = p - q * 16;
        case (md)
            2'd0: r = (rm >= 8) ? 1 : 0;
            2'd1: r = (rm > 8 || (rm == 8 && q % 2 != 0)) ? 1 : 0;
            2'd2: r = 0;
            default: r = (rm != 0 && q % 2 == 0) ? 1 : 0;
        endcase
        s = q + r;
        e.ill = 1'b0; e.sat = 1'b0;
        e.tag = (md == 0) ? "R3" : (md == 1) ? "R4" : (md == 2) ? "R5" : "R6";
        if (f3 == 3'd4) e.tag = {e.tag, "/R2"};
        if (f6 == 6'h3C) begin
            t = longint'(acc) + s;
            if (t > 65535) begin t = 65535; e.sat = 1'b1; e.tag = {e.tag, "/R7"}; end
        end else begin
            t = (f6[1]) ? longint'($signed(acc)) - s : longint'($signed(acc)) + s;
            if (f6[1]) e.tag = {e.tag, "/R9"};
            if (t > 32767)  begin t = 32767;  e.sat = 1'b1; e.tag = {e.tag, "/R8"}; end
            if (t < -32768) begin t = -32768; e.sat = 1'b1; e.tag = {e.tag, "/R8"}; end
        end
        e.res = t[15:0];
        return e;
    endfunction

    task automatic drive(input logic [5:0] f6, input logic [2:0] f3, input logic [6:0] op,
                         input logic [1:0] md, input logic [7:0] v2, input logic [7:0] v1,
                         input logic [7:0] sc, input logic [15:0] acc);
        in_valid = 1'b1; in_funct6 = f6; in_funct3 = f3; in_opcode = op;
        in_rnd = md; in_vs2 = v2; in_vs1 = v1; in_scalar = sc; in_acc = acc;
    endtask

    // R11: streamed results come out in order
    task automatic check_out();
        exp_t e;
        if (out_valid) begin
            if (exp_q.size() == 0) begin
                cmp("R11 unexpected output", 1, 0);
            end else begin
                e = exp_q.pop_front();
                cmp({e.tag, " result"}, out_result, e.res);
                cmp({e.tag, " sat"}, out_sat, e.sat);
                cmp({e.tag, " R1 illegal"}, out_illegal, e.ill);
            end
        end
    endtask

    task automatic push(input logic [5:0] f6, input logic [2:0] f3, input logic [6:0] op,
                        input logic [1:0] md, input logic [7:0] v2, input logic [7:0] v1,
                        input logic [7:0] sc, input logic [15:0] acc);
        @(negedge clk);
        check_out();
        drive(f6, f3, op, md, v2, v1, sc, acc);
        exp_q.push_back(model(f6, f3, op, md, v2, v1, sc, acc));
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check_out();
            in_valid = 1'b0;
        end
        cmp("R11 queue empty", exp_q.size(), 0);
    endtask

    function automatic logic [15:0] acc_pick(input int k);
        case (k % 8)
            0: return 16'h0000;
            1: return 16'h7FF8;
            2: return 16'h8008;
            3: return 16'hFFF8;
            4: return 16'h1234;
            5: return 16'h8000;
            6: return 16'h7FFF;
            default: return 16'hC000;
        endcase
    endfunction

    task automatic sweep(input logic [5:0] f6, input logic [2:0] f3, input int md_fix);
        for (int a = 0; a < 256; a++) begin
            for (int bi = 0; bi < 32; bi++) begin
                logic [7:0] b;
                logic [1:0] md;
                b  = 8'((bi * 8) + (a % 8));
                md = (md_fix >= 0) ? 2'(md_fix) : 2'((a + bi) % 4);
                // R2: the unused second-operand source carries junk
                if (f3 == 3'd4) push(f6, f3, 7'h57, md, 8'(a), ~b, b, acc_pick(a + bi));
                else            push(f6, f3, 7'h57, md, 8'(a), b, ~b, acc_pick(a + bi));
            end
        end
        drain();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        exp_t ea, eb, ec;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13 reset state
        cmp("R13 out_valid", out_valid, 0);
        cmp("R13 sat_sticky", sat_sticky, 0);
        cmp("R13 in_ready", in_ready, 1);
        rst_n = 1'b1;

        // R10: non-clamping element leaves the sticky flag clear
        push(6'h3D, 3'd0, 7'h57, 2'd0, 8'd1, 8'd1, 8'd0, 16'd0);
        drain();
        cmp("R10 sticky clear", sat_sticky, 0);

        // R11: two-edge latency
        @(negedge clk);
        drive(6'h3D, 3'd0, 7'h57, 2'd0, 8'd32, 8'd3, 8'd0, 16'd5);
        @(negedge clk);
        in_valid = 1'b0;
        cmp("R11 not yet valid", out_valid, 0);
        @(negedge clk);
        cmp("R11 valid after two edges", out_valid, 1);
        cmp("R11 latency result", out_result, 16'd11);

        // R1: illegal encodings
        push(6'h3C, 3'd0, 7'h33, 2'd0, 8'd9, 8'd9, 8'd9, 16'hABCD);
        push(6'h3D, 3'd3, 7'h57, 2'd0, 8'd9, 8'd9, 8'd9, 16'h1357);
        push(6'h2A, 3'd0, 7'h57, 2'd0, 8'd9, 8'd9, 8'd9, 16'hFFFF);
        push(6'h3F, 3'd0, 7'h57, 2'd0, 8'hFF, 8'hFF, 8'hFF, 16'h7FFF);
        drain();

        // R3 R4 R5 R6 on the signed variant
        for (int m = 0; m < 4; m++) sweep(6'h3D, 3'd0, m);
        // R7 unsigned, R8 signed scalar, R9 both subtracting orderings
        sweep(6'h3C, 3'd0, -1);
        sweep(6'h3C, 3'd4, -1);
        sweep(6'h3D, 3'd4, -1);
        sweep(6'h3E, 3'd0, -1);
        sweep(6'h3E, 3'd4, -1);
        sweep(6'h3F, 3'd4, -1);
        cmp("R10 sticky set", sat_sticky, 1);
        push(6'h3D, 3'd0, 7'h57, 2'd0, 8'd1, 8'd1, 8'd0, 16'd0);
        drain();
        cmp("R10 sticky holds", sat_sticky, 1);

        // R12 back-pressure
        ea = model(6'h3D, 3'd0, 7'h57, 2'd0, 8'd100, 8'd7, 8'd0, 16'd10);
        eb = model(6'h3E, 3'd4, 7'h57, 2'd1, 8'd200, 8'd0, 8'hF0, 16'd300);
        ec = model(6'h3C, 3'd0, 7'h57, 2'd3, 8'd255, 8'd255, 8'd0, 16'd1);
        @(negedge clk);
        out_ready = 1'b0;
        drive(6'h3D, 3'd0, 7'h57, 2'd0, 8'd100, 8'd7, 8'd0, 16'd10);
        @(negedge clk);
        drive(6'h3E, 3'd4, 7'h57, 2'd1, 8'd200, 8'd0, 8'hF0, 16'd300);
        @(negedge clk);
        cmp("R12 first presented", out_result, ea.res);
        cmp("R12 in_ready low", in_ready, 0);
        drive(6'h3C, 3'd0, 7'h57, 2'd3, 8'd255, 8'd255, 8'd0, 16'd1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            cmp("R12 valid held", out_valid, 1);
            cmp("R12 result held", out_result, ea.res);
            cmp("R12 in_ready held low", in_ready, 0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        cmp("R12 second after release", out_result, eb.res);
        cmp("R12 second sat", out_sat, eb.sat);
        @(negedge clk);
        cmp("R12 third after release", out_result, ec.res);
        @(negedge clk);
        cmp("R12 pipeline empty", out_valid, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule